// File: doc/BRIEF.md
# Double-Buffered Two-Compare PWM Output Channel

This block is a single output channel that turns a shared, externally generated time-base count into a pulse-width-modulated pin. Two active compare values are held against the incoming count. The "set" compare drives the channel level to the programmed polarity. The "reset" compare drives it to the opposite level. When both compares hit on the same count value, the reset compare wins, so the channel can produce both a constant-high and a constant-low output at the edges of the counter range.

Software never writes the active compare values directly. It loads two shadow registers through a small write port. The time base then pulses a period-start strobe, and on that strobe both shadows are copied into the active compares at once, so no period ever runs with half-updated values.

An output-disable input parks the pin at the inactive level while the internal level logic keeps tracking matches. A sticky event flag records match events. A configuration bit chooses whether both compares, or only the reset compare, raise the flag. A write to a dedicated address clears the flag.

Top module: `pwm_dual_cmp_ch`

## Requirements
- R1: After reset, pin_o is 1 (the inverse of the polarity bit, which resets to 0), flag_o is 0, and all shadow and active compare values are 0.
- R2: A write with wr_sel_i = 0 loads the set-compare shadow and wr_sel_i = 1 loads the reset-compare shadow. wr_sel_i = 2 loads the configuration: data bit 0 is the polarity, data bit 1 selects reset-compare-only flagging. wr_sel_i = 3 is a flag-clear request, and its data is ignored.
- R3: The active compare values change only on a clock where cyc_start_i is 1, taking the shadow contents at that clock. A shadow write does not change which count values match until the next strobe.
- R4: When cnt_i equals the active reset compare, pin_o becomes the inverse of the polarity bit one clock later.
- R5: When cnt_i equals the active set compare and not the reset compare, pin_o becomes equal to the polarity bit one clock later.
- R6: When cnt_i equals both active compares on the same clock, the reset-compare action wins and pin_o becomes the inverse of the polarity bit.
- R7: With the reset compare set to a value the counter never reaches, only set-compare hits occur, and the output stays at the polarity level for whole periods (0% duty for polarity 0).
- R8: While out_dis_i is 1, pin_o is forced to the inverse of the polarity bit from the next clock on. The internal level keeps following matches, and pin_o shows that level again one clock after out_dis_i drops.
- R9: A reset-compare hit always sets flag_o on the next clock. A set-compare hit also sets it when the reset-only flagging bit is 0, and does not set it when that bit is 1.
- R10: flag_o stays 1 until a flag-clear write, which drops it on the next clock. A clear in the same clock as a flag-setting hit leaves flag_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Shared time-base count value |
| cyc_start_i | input | 1 | One-clock strobe at the start of each time-base period |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select (0 set shadow, 1 reset shadow, 2 config, 3 flag clear) |
| wr_data_i | input | CNT_W | Write data |
| out_dis_i | input | 1 | Force the pin to the inactive level |
| pin_o | output | 1 | Registered PWM output pin |
| flag_o | output | 1 | Sticky match-event flag |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it. A count value, strobe, write or disable presented before a rising edge shows on pin_o and flag_o once that edge has passed. A shadow write reaches the compare logic only one strobe later. The bench drives each input set just after a rising edge, lets one edge pass, and samples a nanosecond after it. Every expected value therefore refers to the compare values active during the clock being checked. Idle and write clocks present a count of 0xFF, which matches no programmed compare, so register writes never cause a match on their own.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;

  // register select codes on the write port
  typedef enum logic [1:0] {
    SEL_SHADOW_SET = 2'd0,
    SEL_SHADOW_RST = 2'd1,
    SEL_CONFIG     = 2'd2,
    SEL_FLAG_CLR   = 2'd3
  } wr_sel_e;

  // compare slot indices
  localparam int unsigned SLOT_SET = 0;
  localparam int unsigned SLOT_RST = 1;
  localparam int unsigned N_SLOTS  = 2;

  typedef struct packed {
    logic rst_only_flag;  // data bit 1
    logic pol;            // data bit 0
  } chan_cfg_t;

endpackage

// File: rtl/pwm_ch_regs.sv
module pwm_ch_regs
  import pwm_ch_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cyc_start_i,
  input  logic                            wr_en_i,
  input  logic [1:0]                      wr_sel_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  output logic [N_SLOTS-1:0][CNT_W-1:0]   active_o,
  output chan_cfg_t                       cfg_o,
  output logic                            flag_clr_o
);

  logic [N_SLOTS-1:0][CNT_W-1:0] shadow_q;
  logic [N_SLOTS-1:0][CNT_W-1:0] active_q;
  chan_cfg_t                     cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
      cfg_q    <= '0;
    end else begin
      for (int unsigned s = 0; s < N_SLOTS; s++) begin
        if (wr_en_i && (wr_sel_i == 2'(s)))
          shadow_q[s] <= wr_data_i;
      end
      // transfer happens with the shadow contents held before this edge
      if (cyc_start_i)
        active_q <= shadow_q;
      if (wr_en_i && (wr_sel_i == SEL_CONFIG))
        cfg_q <= chan_cfg_t'(wr_data_i[1:0]);
    end
  end

  assign active_o   = active_q;
  assign cfg_o      = cfg_q;
  assign flag_clr_o = wr_en_i && (wr_sel_i == SEL_FLAG_CLR);

endmodule

// File: rtl/pwm_ch_match.sv
module pwm_ch_match
  import pwm_ch_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [N_SLOTS-1:0][CNT_W-1:0] active_i,
  output logic [N_SLOTS-1:0]            hit_o
);

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign hit_o[g] = (cnt_i == active_i[g]);
  end

endmodule

// File: rtl/pwm_ch_out.sv
module pwm_ch_out
  import pwm_ch_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SLOTS-1:0] hit_i,
  input  chan_cfg_t          cfg_i,
  input  logic               out_dis_i,
  input  logic               flag_clr_i,
  output logic               lvl_o,
  output logic               pin_o,
  output logic               flag_o
);

  logic lvl_q, pin_q, flag_q;
  logic lvl_nxt, set_evt;

  always_comb begin
    // reset-compare has priority over set-compare
    if (hit_i[SLOT_RST])      lvl_nxt = ~cfg_i.pol;
    else if (hit_i[SLOT_SET]) lvl_nxt = cfg_i.pol;
    else                      lvl_nxt = lvl_q;
  end

  assign set_evt = hit_i[SLOT_RST] | (hit_i[SLOT_SET] & ~cfg_i.rst_only_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b1;  // polarity resets to 0, inactive level is 1
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_nxt;
      pin_q  <= out_dis_i ? ~cfg_i.pol : lvl_nxt;
      if (set_evt)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign lvl_o  = lvl_q;
  assign pin_o  = pin_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/pwm_dual_cmp_ch.sv
module pwm_dual_cmp_ch
  import pwm_ch_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cyc_start_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             out_dis_i,
  output logic             pin_o,
  output logic             flag_o
);

  logic [N_SLOTS-1:0][CNT_W-1:0] active;
  logic [N_SLOTS-1:0]            hit;
  chan_cfg_t                     cfg;
  logic                          flag_clr;
  logic                          lvl;

  pwm_ch_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cyc_start_i (cyc_start_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .active_o    (active),
    .cfg_o       (cfg),
    .flag_clr_o  (flag_clr)
  );

  pwm_ch_match #(.CNT_W(CNT_W)) u_match (
    .cnt_i    (cnt_i),
    .active_i (active),
    .hit_o    (hit)
  );

  pwm_ch_out u_out (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit),
    .cfg_i      (cfg),
    .out_dis_i  (out_dis_i),
    .flag_clr_i (flag_clr),
    .lvl_o      (lvl),
    .pin_o      (pin_o),
    .flag_o     (flag_o)
  );

endmodule

// File: rtl/pwm_dual_cmp_ch_chk.sv
module pwm_dual_cmp_ch_chk
  import pwm_ch_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            cyc_start_i,
  input logic                            out_dis_i,
  input logic                            pin_o,
  input logic                            flag_o,
  input logic [N_SLOTS-1:0][CNT_W-1:0]   active,
  input logic [N_SLOTS-1:0]              hit,
  input chan_cfg_t                       cfg,
  input logic                            lvl
);

  // R3: active compares move only on the period strobe
  a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
    !cyc_start_i |=> $stable(active));

  // R4 / R6: reset-compare hit drives the inactive level, whatever the set hit
  a_r4_rst_hit_level: assert property (@(posedge clk) disable iff (rst)
    hit[SLOT_RST] |=> (lvl == ~$past(cfg.pol)));

  // R5: lone set-compare hit drives the polarity level
  a_r5_set_hit_level: assert property (@(posedge clk) disable iff (rst)
    (hit[SLOT_SET] && !hit[SLOT_RST]) |=> (lvl == $past(cfg.pol)));

  // R5: no hit, level holds
  a_r5_level_hold: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> $stable(lvl));

  // R8: disable parks the pin at the inactive level
  a_r8_disable_pin: assert property (@(posedge clk) disable iff (rst)
    out_dis_i |=> (pin_o == ~$past(cfg.pol)));

  // R9: qualifying hit sets the flag
  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    (hit[SLOT_RST] || (hit[SLOT_SET] && !cfg.rst_only_flag)) |=> flag_o);

  // R10: flag only rises on a qualifying hit
  a_r10_flag_rise: assert property (@(posedge clk) disable iff (rst)
    (!hit[SLOT_RST] && !(hit[SLOT_SET] && !cfg.rst_only_flag)) |=> !$rose(flag_o));

endmodule

bind pwm_dual_cmp_ch pwm_dual_cmp_ch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cyc_start_i (cyc_start_i),
  .out_dis_i   (out_dis_i),
  .pin_o       (pin_o),
  .flag_o      (flag_o),
  .active      (active),
  .hit         (hit),
  .cfg         (cfg),
  .lvl         (lvl)
);

// File: tb/pwm_dual_cmp_ch_bench.sv
`timescale 1ns/1ps
module pwm_dual_cmp_ch_bench;

  localparam int unsigned CNT_W = 8;
  localparam logic [7:0]  IDLE  = 8'hFF;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cnt_i = IDLE;
  logic             cyc_start_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_sel_i = 2'd0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             out_dis_i = 1'b0;
  logic             pin_o, flag_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_dual_cmp_ch #(.CNT_W(CNT_W)) u_pwm_dual_cmp_ch (
    .clk, .rst, .cnt_i, .cyc_start_i, .wr_en_i, .wr_sel_i,
    .wr_data_i, .out_dis_i, .pin_o, .flag_o
  );

  // {strobe, expected pin, count}; set compare 2, reset compare 6, polarity 0
  localparam logic [9:0] VEC [16] = '{
    {1'b1, 1'b1, 8'd0}, {1'b0, 1'b1, 8'd1}, {1'b0, 1'b0, 8'd2}, {1'b0, 1'b0, 8'd3},
    {1'b0, 1'b0, 8'd4}, {1'b0, 1'b0, 8'd5}, {1'b0, 1'b1, 8'd6}, {1'b0, 1'b1, 8'd7},
    {1'b1, 1'b1, 8'd0}, {1'b0, 1'b1, 8'd1}, {1'b0, 1'b0, 8'd2}, {1'b0, 1'b0, 8'd3},
    {1'b0, 1'b0, 8'd4}, {1'b0, 1'b0, 8'd5}, {1'b0, 1'b1, 8'd6}, {1'b0, 1'b1, 8'd7}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // one clock: drive, pass an edge, sample 1 ns later
  task automatic cyc(input logic [7:0] c, input logic stb, input logic dis,
                     input logic we, input logic [1:0] sel, input logic [7:0] d);
    cnt_i = c; cyc_start_i = stb; out_dis_i = dis;
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk); #1;
    cyc_start_i = 1'b0; wr_en_i = 1'b0; cnt_i = IDLE;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cyc(IDLE, 1'b0, 1'b0, 1'b1, sel, d);
  endtask

  task automatic tick(input logic [7:0] c, input logic stb);
    cyc(c, stb, 1'b0, 1'b0, 2'd0, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    check("R1 pin after reset", pin_o, 1'b1);
    check("R1 flag after reset", flag_o, 1'b0);

    // R2: load shadows and config
    wr(2'd0, 8'd2);
    wr(2'd1, 8'd6);
    wr(2'd2, 8'd0);

    // vector table; first strobe still uses zero actives (R1, R6 at count 0)
    for (int i = 0; i < 16; i++) begin
      tick(VEC[i][7:0], VEC[i][9]);
      check($sformatf("R3 R4 R5 table step %0d", i), pin_o, VEC[i][8]);
    end

    tick(8'd2, 1'b0);
    check("R5 set hit drives polarity", pin_o, 1'b0);

    // R6: both compares at 4, move in at a strobe on a non-matching count
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd4);
    tick(8'd3, 1'b1);
    check("R3 strobe clock uses old actives", pin_o, 1'b0);
    tick(8'd4, 1'b0);
    check("R2 R6 simultaneous hit reset wins", pin_o, 1'b1);

    // R3: shadow write alone must not change matching
    wr(2'd0, 8'd7);
    tick(8'd7, 1'b0);
    check("R3 shadow not active before strobe", pin_o, 1'b1);

    // R7: reset compare beyond period end
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd200);
    tick(8'd0, 1'b1);
    check("R7 strobe clock no hit", pin_o, 1'b1);
    begin
      int bad = 0;
      bit low = 0;
      for (int k = 1; k < 16; k++) begin
        tick(8'(k % 8), (k % 8) == 0);
        if (k == 3) low = 1;
        if (pin_o !== (low ? 1'b0 : 1'b1)) bad++;
      end
      n_run++;
      if (bad != 0) begin
        n_fail++;
        $display("FAIL R7 zero duty: got %0d bad steps expected 0", bad);
      end
    end

    // R4/R5 with polarity 1
    wr(2'd2, 8'd1);
    wr(2'd1, 8'd6);
    tick(8'd0, 1'b1);
    tick(8'd3, 1'b0);
    check("R5 set hit polarity 1", pin_o, 1'b1);
    tick(8'd6, 1'b0);
    check("R4 reset hit polarity 1", pin_o, 1'b0);

    // R8: disable with polarity 0; level becomes 0 via set hit at 3
    wr(2'd2, 8'd0);
    cyc(8'd3, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    check("R8 disabled pin inactive", pin_o, 1'b1);
    cyc(8'd6, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    cyc(8'd3, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    check("R8 disabled pin stays inactive", pin_o, 1'b1);
    tick(IDLE, 1'b0);
    check("R8 level tracked during disable", pin_o, 1'b0);

    // R9/R10 flag
    wr(2'd3, 8'hA5);
    check("R10 clear drops flag", flag_o, 1'b0);
    wr(2'd2, 8'd2);
    tick(8'd3, 1'b0);
    check("R9 set hit ignored in reset-only mode", flag_o, 1'b0);
    tick(8'd6, 1'b0);
    check("R9 reset hit sets flag", flag_o, 1'b1);
    wr(2'd3, 8'd0);
    wr(2'd2, 8'd0);
    check("R10 flag cleared", flag_o, 1'b0);
    tick(8'd3, 1'b0);
    check("R9 set hit sets flag", flag_o, 1'b1);
    wr(2'd3, 8'd0);
    cyc(8'd3, 1'b0, 1'b0, 1'b1, 2'd3, 8'd0);
    check("R10 set wins over clear", flag_o, 1'b1);
    wr(2'd3, 8'd0);
    check("R10 clear alone", flag_o, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule